// File: doc/BRIEF.md
# DMA Request Arbiter with Single-Cycle and Demand Modes

This block sits between a set of peripheral DMA request lines and the system bus owner. When an eligible request is present and the arbiter is idle, it asks for the shared bus. Once the bus owner grants the bus, it picks one channel by fixed priority and acknowledges that channel for one or more fixed-length bus cycles. A grant is never taken away from a channel part way through its transaction. A higher-priority request that arrives meanwhile is considered at the next arbitration.

Each channel runs in one of two modes. In single-cycle mode, one grant covers exactly one transfer. The bus is then released and has to be requested again. In demand mode, the served channel's request line is sampled a fixed number of clocks before the current cycle ends. If the line is still high, another cycle follows at once, with no re-arbitration and no release of the bus. A memory-refresh request is held until no transaction is active. It is then served ahead of any new DMA grant, and it blocks further grants until the refresh is reported finished.

The transfer strobe pulses once per completed cycle. A width flag tells whether the served channel moves a byte or a 16-bit word.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `dma_ack`, `bus_hold_req`, `xfer_strobe`, `xfer_wide` and `refresh_ack` are all 0. Every channel starts in single-cycle mode.
- R2: From idle, an eligible request raises `bus_hold_req` one clock later. No `dma_ack` bit rises before the arbiter has seen `bus_hold_grant` high while holding the bus. `bus_hold_req` is high throughout every acknowledged cycle.
- R3: At arbitration, the acknowledged channel is the lowest-numbered eligible requester. At most one `dma_ack` bit is high at any time.
- R4: Channel 4 is reserved. Its request never raises `bus_hold_req` and never receives `dma_ack`.
- R5: Each bus cycle lasts CYC_CLKS clocks (default 4) with `dma_ack` steady. `xfer_strobe` is high only on the last clock of each cycle.
- R6: For a channel in single-cycle mode (mode bit 0), `bus_hold_req` is low in the clock after the strobe. The next grant, even to the same channel, needs a fresh `bus_hold_grant`.
- R7: For a channel in demand mode (mode bit 1), the request is sampled at clock index CYC_CLKS-1-SAMPLE_BEFORE of the cycle, counting from 0 (index 2 by default). If the sampled request is high, the next cycle starts straight after the strobe with `dma_ack` and `bus_hold_req` unbroken. If it is low, the bus is released.
- R8: Once a channel is acknowledged, `dma_ack` does not change until that channel's transaction ends, whatever other requests arrive.
- R9: `xfer_wide` is 1 while channels 5 to 7 are acknowledged and 0 for channels 0 to 3.
- R10: A refresh request is latched. It is served only when no transaction is active, by raising `refresh_ack`, and it is served before any new DMA grant. `refresh_ack` and `dma_ack` are never high together. `refresh_ack` stays high until `refresh_done`, and no DMA grant is made in that time.
- R11: A write to a channel's mode bit (`mode_wr_en`, `mode_wr_ch`, `mode_wr_val`; 0 = single-cycle, 1 = demand) takes effect one clock later, except while that channel is acknowledged. In that case the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | NUM_CH | Per-channel DMA request lines |
| mode_wr_en | input | 1 | Mode bit write strobe |
| mode_wr_ch | input | CH_W | Channel whose mode bit is written |
| mode_wr_val | input | 1 | Mode value: 0 single-cycle, 1 demand |
| bus_hold_grant | input | 1 | Bus granted by the system bus owner |
| refresh_req | input | 1 | Memory refresh request (latched) |
| refresh_done | input | 1 | Refresh finished |
| dma_ack | output | NUM_CH | One-hot acknowledge of the served channel |
| bus_hold_req | output | 1 | Request to hold the system bus |
| xfer_strobe | output | 1 | Pulse on the last clock of each bus cycle |
| xfer_wide | output | 1 | Served channel moves 16 bits per cycle |
| refresh_ack | output | 1 | Refresh is being serviced |

## Verification
The hardest situations to reach are those where a demand-mode request falls exactly at the sample clock, where a refresh and a higher-priority request both land in the middle of a transaction, and where a mode write targets the channel being served. Directed phases create each of these. One holds a wide channel in demand mode and drops its request just around the sample clock. One raises channel 0 and a refresh pulse while channel 2 is acknowledged. One writes the served channel's mode bit during its own cycle. A long pseudo-random phase then mixes request patterns, a bus owner that delays its grant, refresh pulses and mode writes, with every output compared against a behavioural model on each clock.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int DEF_NUM_CH        = 8;
    localparam int DEF_RSVD_CH       = 4;
    localparam int DEF_WIDE_FIRST    = 5;
    localparam int DEF_CYC_CLKS      = 4;
    localparam int DEF_SAMPLE_BEFORE = 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BUSREQ  = 2'd1,
        ST_XFER    = 2'd2,
        ST_REFRESH = 2'd3
    } arb_state_e;

    // Channels at or above the first wide channel carry 16-bit data.
    function automatic logic ch_is_wide(input int unsigned ch, input int unsigned first);
        return ch >= first;
    endfunction

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NUM_CH  = 8,
    parameter int RSVD_CH = 4,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any_valid,
    output logic [CH_W-1:0]   pick_ch
);
    logic [NUM_CH-1:0] eligible;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_mask
            if (g == RSVD_CH) begin : g_rsvd
                assign eligible[g] = 1'b0;
            end else begin : g_open
                assign eligible[g] = req[g];
            end
        end
    endgenerate

    assign any_valid = |eligible;

    // Lowest index wins: scan downward so the last hit is the smallest.
    always_comb begin
        pick_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (eligible[i]) pick_ch = CH_W'(i);
        end
    end
endmodule

// File: rtl/dma_mode_regs.sv
module dma_mode_regs #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_val,
    input  logic              busy,
    input  logic [CH_W-1:0]   busy_ch,
    output logic [NUM_CH-1:0] mode_q
);
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_bit
            logic hit, locked;
            assign hit    = wr_en && (wr_ch == CH_W'(g));
            assign locked = busy && (busy_ch == CH_W'(g));
            always_ff @(posedge clk) begin
                if (rst)                 mode_q[g] <= 1'b0;
                else if (hit && !locked) mode_q[g] <= wr_val;
            end
        end
    endgenerate
endmodule

// File: rtl/dma_cycle_timer.sv
module dma_cycle_timer #(
    parameter int CYC_CLKS      = 4,
    parameter int SAMPLE_BEFORE = 1,
    localparam int CNT_W        = $clog2(CYC_CLKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic at_sample,
    output logic at_last
);
    logic [CNT_W-1:0] cnt_q;

    assign at_last   = run && (cnt_q == CNT_W'(CYC_CLKS - 1));
    assign at_sample = run && (cnt_q == CNT_W'(CYC_CLKS - 1 - SAMPLE_BEFORE));

    always_ff @(posedge clk) begin
        if (rst || !run || at_last) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH        = DEF_NUM_CH,
    parameter int RSVD_CH       = DEF_RSVD_CH,
    parameter int WIDE_FIRST    = DEF_WIDE_FIRST,
    parameter int CYC_CLKS      = DEF_CYC_CLKS,
    parameter int SAMPLE_BEFORE = DEF_SAMPLE_BEFORE,
    localparam int CH_W         = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] dma_req,
    input  logic              mode_wr_en,
    input  logic [CH_W-1:0]   mode_wr_ch,
    input  logic              mode_wr_val,
    input  logic              bus_hold_grant,
    input  logic              refresh_req,
    input  logic              refresh_done,
    output logic [NUM_CH-1:0] dma_ack,
    output logic              bus_hold_req,
    output logic              xfer_strobe,
    output logic              xfer_wide,
    output logic              refresh_ack
);
    arb_state_e        state_q;
    logic [CH_W-1:0]   cur_ch_q;
    logic              chain_q;
    logic              refresh_pend_q;
    logic              any_valid, at_sample, at_last, in_xfer, refresh_seen, cont;
    logic [CH_W-1:0]   pick_ch;
    logic [NUM_CH-1:0] mode_q;

    assign in_xfer      = (state_q == ST_XFER);
    assign refresh_seen = refresh_pend_q | refresh_req;

    dma_prio_pick #(.NUM_CH(NUM_CH), .RSVD_CH(RSVD_CH)) u_pick (
        .req(dma_req), .any_valid(any_valid), .pick_ch(pick_ch)
    );

    dma_mode_regs #(.NUM_CH(NUM_CH)) u_mode (
        .clk(clk), .rst(rst), .wr_en(mode_wr_en), .wr_ch(mode_wr_ch),
        .wr_val(mode_wr_val), .busy(in_xfer), .busy_ch(cur_ch_q), .mode_q(mode_q)
    );

    dma_cycle_timer #(.CYC_CLKS(CYC_CLKS), .SAMPLE_BEFORE(SAMPLE_BEFORE)) u_timer (
        .clk(clk), .rst(rst), .run(in_xfer), .at_sample(at_sample), .at_last(at_last)
    );

    // Chaining decision: sampled early, or live when the sample point is the last clock.
    generate
        if (SAMPLE_BEFORE == 0) begin : g_live
            assign cont = mode_q[cur_ch_q] & dma_req[cur_ch_q];
        end else begin : g_early
            assign cont = chain_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            cur_ch_q       <= '0;
            chain_q        <= 1'b0;
            refresh_pend_q <= 1'b0;
        end else begin
            refresh_pend_q <= refresh_req |
                              (refresh_pend_q & !(state_q == ST_REFRESH && refresh_done));
            if (at_sample) chain_q <= mode_q[cur_ch_q] & dma_req[cur_ch_q];
            unique case (state_q)
                ST_IDLE: begin
                    if (refresh_seen)   state_q <= ST_REFRESH;
                    else if (any_valid) state_q <= ST_BUSREQ;
                end
                ST_BUSREQ: begin
                    if (refresh_seen) begin
                        state_q <= ST_IDLE;
                    end else if (bus_hold_grant) begin
                        if (any_valid) begin
                            state_q  <= ST_XFER;
                            cur_ch_q <= pick_ch;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_XFER: begin
                    if (at_last && !cont) state_q <= ST_IDLE;
                end
                ST_REFRESH: begin
                    if (refresh_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dma_ack = '0;
        if (in_xfer) dma_ack[cur_ch_q] = 1'b1;
    end

    assign bus_hold_req = (state_q == ST_BUSREQ) || in_xfer;
    assign xfer_strobe  = at_last;
    assign xfer_wide    = in_xfer && ch_is_wide(32'(cur_ch_q), WIDE_FIRST);
    assign refresh_ack  = (state_q == ST_REFRESH);

    // ---------------- assertions ----------------
    p_ack_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dma_ack));

    p_rsvd_silent_r4: assert property (@(posedge clk) disable iff (rst)
        !dma_ack[RSVD_CH]);

    p_ack_under_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (|dma_ack) |-> bus_hold_req);

    p_no_preempt_r8: assert property (@(posedge clk) disable iff (rst)
        ((|dma_ack) && !xfer_strobe) |=> $stable(dma_ack));

    p_single_release_r6: assert property (@(posedge clk) disable iff (rst)
        (xfer_strobe && !mode_q[cur_ch_q]) |=> !bus_hold_req);

    p_refresh_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(refresh_ack && (|dma_ack)));

    p_refresh_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (refresh_ack && !refresh_done) |=> refresh_ack);

    p_strobe_in_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_strobe |-> (|dma_ack));
endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
    import dma_arb_pkg::*;

    localparam int NCH  = DEF_NUM_CH;
    localparam int CW   = $clog2(NCH);
    localparam int CYC  = DEF_CYC_CLKS;
    localparam int SB   = DEF_SAMPLE_BEFORE;
    localparam int RSV  = DEF_RSVD_CH;
    localparam int WIDE = DEF_WIDE_FIRST;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] dma_req = '0;
    logic           mode_wr_en = 1'b0;
    logic [CW-1:0]  mode_wr_ch = '0;
    logic           mode_wr_val = 1'b0;
    logic           bus_hold_grant = 1'b0;
    logic           refresh_req = 1'b0;
    logic           refresh_done = 1'b0;
    logic [NCH-1:0] dma_ack;
    logic           bus_hold_req, xfer_strobe, xfer_wide, refresh_ack;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_req_arbiter u_dut (
        .clk(clk), .rst(rst), .dma_req(dma_req), .mode_wr_en(mode_wr_en),
        .mode_wr_ch(mode_wr_ch), .mode_wr_val(mode_wr_val),
        .bus_hold_grant(bus_hold_grant), .refresh_req(refresh_req),
        .refresh_done(refresh_done), .dma_ack(dma_ack), .bus_hold_req(bus_hold_req),
        .xfer_strobe(xfer_strobe), .xfer_wide(xfer_wide), .refresh_ack(refresh_ack)
    );

    // ---------------- behavioural reference ----------------
    // phase: 0 idle, 1 waiting for bus, 2 moving data, 3 refreshing
    int m_phase, m_ch, m_clk, m_pend;
    bit m_go;
    bit m_mode [NCH];

    function automatic int lowest_req(input logic [NCH-1:0] r);
        for (int i = 0; i < NCH; i++) if (r[i] && i != RSV) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_ch = 0; m_clk = 0; m_pend = 0; m_go = 0;
            for (int i = 0; i < NCH; i++) m_mode[i] = 0;
        end else begin
            int  who;
            bit  seen, wr_ok, last;
            who   = lowest_req(dma_req);
            seen  = (m_pend != 0) || refresh_req;
            wr_ok = mode_wr_en && !(m_phase == 2 && m_ch == int'(mode_wr_ch));
            last  = (m_phase == 2) && (m_clk == CYC - 1);
            if (m_phase == 2 && m_clk == CYC - 1 - SB) m_go = m_mode[m_ch] && dma_req[m_ch];
            if (refresh_req) m_pend = 1;
            else if (m_phase == 3 && refresh_done) m_pend = 0;
            case (m_phase)
                0: if (seen) m_phase = 3; else if (who >= 0) m_phase = 1;
                1: if (seen) m_phase = 0;
                   else if (bus_hold_grant) begin
                       if (who >= 0) begin m_phase = 2; m_ch = who; m_clk = 0; end
                       else m_phase = 0;
                   end
                2: if (last) begin
                       m_clk = 0;
                       if (!m_go) m_phase = 0;
                   end else m_clk++;
                3: if (refresh_done) m_phase = 0;
                default: m_phase = 0;
            endcase
            if (wr_ok) m_mode[mode_wr_ch] = mode_wr_val;
        end
    end

    task automatic fail_line(input string tag, input longint act, input longint exp);
        n_bad++;
        $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) fail_line(tag, act, exp);
    endtask

    // Compare every output against the model, away from the clock edge.
    task automatic compare_all();
        logic [NCH-1:0] e_ack;
        e_ack = '0;
        if (m_phase == 2) e_ack[m_ch] = 1'b1;
        check(dma_ack == e_ack, "R3/R4/R6/R7/R8/R11 dma_ack", dma_ack, e_ack);
        check(bus_hold_req == (m_phase == 1 || m_phase == 2), "R2 bus_hold_req",
              bus_hold_req, (m_phase == 1 || m_phase == 2));
        check(xfer_strobe == (m_phase == 2 && m_clk == CYC - 1), "R5 xfer_strobe",
              xfer_strobe, (m_phase == 2 && m_clk == CYC - 1));
        check(xfer_wide == (m_phase == 2 && m_ch >= WIDE), "R9 xfer_wide",
              xfer_wide, (m_phase == 2 && m_ch >= WIDE));
        check(refresh_ack == (m_phase == 3), "R10 refresh_ack", refresh_ack, (m_phase == 3));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic grant_follow(input int n);
        for (int k = 0; k < n; k++) begin
            bus_hold_grant = bus_hold_req;
            refresh_done   = refresh_ack;
            step();
        end
    endtask

    task automatic set_mode(input int ch, input bit v);
        mode_wr_en = 1'b1; mode_wr_ch = CW'(ch); mode_wr_val = v;
        step();
        mode_wr_en = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int hold_seen;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(dma_ack == '0 && !bus_hold_req && !xfer_strobe && !xfer_wide && !refresh_ack,
              "R1 reset outputs", {dma_ack, bus_hold_req, refresh_ack}, 0);
        rst = 1'b0;
        step();
        check(dma_ack == '0 && !bus_hold_req, "R1 first cycle after reset",
              {dma_ack, bus_hold_req}, 0);

        // R4: the reserved channel alone never raises a bus request
        dma_req = NCH'(1) << RSV;
        hold_seen = 0;
        for (int k = 0; k < 20; k++) begin
            bus_hold_grant = 1'b1;
            step();
            if (bus_hold_req || dma_ack != '0) hold_seen++;
        end
        check(hold_seen == 0, "R4 reserved channel ignored", hold_seen, 0);
        bus_hold_grant = 1'b0;

        // R2: hold request without grant keeps ack low
        dma_req = NCH'(1) << 3;
        repeat (5) step();
        check(bus_hold_req && dma_ack == '0, "R2 ack waits for grant", dma_ack, 0);

        // R6/R8/R10: single-cycle channel 2, channel 0 and refresh arrive mid-cycle
        dma_req = NCH'(1) << 2;
        grant_follow(3);
        dma_req = (NCH'(1) << 2) | NCH'(1);
        refresh_req = 1'b1; step(); refresh_req = 1'b0;
        grant_follow(30);
        dma_req = '0;
        grant_follow(10);

        // R7/R9/R11: demand mode on wide channel 6, request dropped around the sample clock
        set_mode(6, 1'b1);
        dma_req = NCH'(1) << 6;
        grant_follow(12);
        set_mode(6, 1'b0);            // R11: dropped while channel 6 is acknowledged
        grant_follow(5);
        dma_req = '0;
        grant_follow(1);
        dma_req = NCH'(1) << 6;
        grant_follow(1);
        dma_req = '0;
        grant_follow(12);
        set_mode(6, 1'b0);            // R11: accepted while idle
        dma_req = NCH'(1) << 6;
        grant_follow(20);
        dma_req = '0;
        grant_follow(10);

        // Mixed pseudo-random traffic
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 7) == 0) dma_req = NCH'($urandom);
            bus_hold_grant = bus_hold_req && ($urandom_range(0, 2) != 0);
            refresh_req    = ($urandom_range(0, 60) == 0);
            refresh_done   = refresh_ack && ($urandom_range(0, 3) == 0);
            mode_wr_en     = ($urandom_range(0, 9) == 0);
            mode_wr_ch     = CW'($urandom_range(0, NCH - 1));
            mode_wr_val    = 1'($urandom);
            step();
        end
        refresh_req = 1'b0; mode_wr_en = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule